// File: doc/BRIEF.md
# RMII Receive Byte Assembler

This block is the receive half of a MAC's reduced media-independent interface. It registers the PHY's carrier/data-valid strobe and 2-bit receive bus on the 50 MHz reference clock. It skips the forced-zero dibits that follow carrier detection and the out-of-band codes sent while the strobe is low. It then tracks the preamble, locks byte alignment on the start-of-frame delimiter and packs the dibits that follow into bytes.

The output is a stream of bytes. Each byte comes with a one-cycle valid pulse, and the first byte of a frame also carries a start-of-frame marker. A separate one-cycle end-of-frame pulse follows the fall of the strobe and carries an alignment-error flag. A static rate-select input picks 100 Mb/s operation, with one dibit per clock, or 10 Mb/s operation, with one dibit per ten clocks.

Top module: `rmii_rx_assembler`

## Requirements
- R1: While rst_ni is low, byte_o, valid_o, sof_o, eof_o and align_err_o are all zero.
- R2: Dibits are packed least significant pair first: the first dibit of a byte becomes bits [1:0] and the fourth becomes bits [7:6].
- R3: Any number of 00 dibits received with the strobe high before the first non-zero dibit are discarded and produce no output.
- R4: While the strobe is low, any value on rxd_i, including 01, 10 and 11, produces no output and does not disturb the decoding of the next frame.
- R5: Byte alignment starts on the dibit after the delimiter pair 01 then 11, for any preamble length. The first byte after it carries sof_o=1 and later bytes carry sof_o=0.
- R6: Once a delimiter has been seen, the fall of the strobe yields one eof_o pulse. align_err_o is 0 when the frame held a whole number of bytes.
- R7: If the strobe falls with 1 to 3 dibits of a byte collected, that partial byte is never output and align_err_o=1 with eof_o.
- R8: With rate_10m_i=1, each dibit is held ten clocks and is sampled once per ten-clock period, with the period aligned to the first non-zero dibit of the frame.
- R9: valid_o and eof_o rise two clock edges after the input change that causes them: at the second edge after the final dibit of a byte (or the low strobe) is first presented.
- R10: valid_o is never high in two adjacent cycles, sof_o is only high with valid_o, and valid_o and eof_o are never high together.
- R11: If the strobe falls before a delimiter has been seen, no byte and no eof_o is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_10m_i | input | 1 | 1 selects 10 Mb/s, 0 selects 100 Mb/s |
| crs_dv_i | input | 1 | Carrier sense / receive data valid strobe |
| rxd_i | input | 2 | Receive dibit |
| byte_o | output | 8 | Assembled byte, meaningful when valid_o is high |
| valid_o | output | 1 | One-cycle byte strobe |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| align_err_o | output | 1 | Frame ended on a partial byte, valid with eof_o |

## Verification
A byte appears on valid_o exactly two clock edges after its fourth dibit is first driven, and eof_o appears two edges after the strobe is driven low. This holds at both rates, because at 10 Mb/s the sample point is the first clock of each ten-clock hold. The driver stamps every expected byte and end-of-frame item with the cycle in which it drives the deciding input plus two. The monitor samples on the falling clock edge and checks the value and that exact arrival cycle, so a result that arrives early, late or unasked is reported.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_PRE, ST_DATA} rx_state_e;
  localparam logic [1:0] PRE_DIBIT = 2'b01;
  localparam logic [1:0] SFD_TAIL  = 2'b11;
endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler #(
  parameter int DIBIT_W  = 2,
  parameter int SLOW_DIV = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rate_10m_i,
  input  logic               crs_dv_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  input  logic               restart_i,
  output logic               crs_o,
  output logic [DIBIT_W-1:0] rxd_o,
  output logic               tick_o
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_o <= 1'b0;
      rxd_o <= '0;
      cnt_q <= '0;
    end else begin
      crs_o <= crs_dv_i;
      rxd_o <= rxd_i;
      // phase restarts on the first non-zero dibit of a frame
      if (restart_i || cnt_q == CNT_LAST) cnt_q <= '0;
      else                                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = !rate_10m_i || (cnt_q == CNT_LAST);
endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
  import rmii_rx_pkg::*;
#(
  parameter int DIBIT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               crs_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  input  logic               tick_i,
  output logic               restart_o,
  output logic               shift_o,
  output logic               start_o,
  output logic               end_o
);
  rx_state_e          state_q, state_d;
  logic [DIBIT_W-1:0] last_q;

  always_comb begin
    state_d   = state_q;
    restart_o = 1'b0;
    shift_o   = 1'b0;
    start_o   = 1'b0;
    end_o     = 1'b0;
    unique case (state_q)
      ST_HUNT: if (crs_i && rxd_i != '0) begin
        state_d   = ST_PRE;
        restart_o = 1'b1;
      end
      ST_PRE: begin
        if (!crs_i) state_d = ST_HUNT;
        else if (tick_i && last_q == PRE_DIBIT && rxd_i == SFD_TAIL) begin
          state_d = ST_DATA;
          start_o = 1'b1;
        end
      end
      ST_DATA: begin
        if (!crs_i) begin
          state_d = ST_HUNT;
          end_o   = 1'b1;
        end else if (tick_i) shift_o = 1'b1;
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      if (restart_o || (state_q == ST_PRE && tick_i)) last_q <= rxd_i;
    end
  end
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
  parameter int DIBIT_W = 2,
  parameter int BYTE_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIBIT_W-1:0] dibit_i,
  input  logic               shift_i,
  input  logic               start_i,
  input  logic               end_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               valid_o,
  output logic               sof_o,
  output logic               eof_o,
  output logic               align_err_o
);
  localparam int NPB = BYTE_W / DIBIT_W;
  localparam int NW  = (NPB > 1) ? $clog2(NPB) : 1;
  localparam logic [NW-1:0] IDX_LAST = NW'(NPB - 1);

  logic [BYTE_W-DIBIT_W-1:0] sh_q;
  logic [NW-1:0]             idx_q;
  logic                      first_q;
  logic [BYTE_W-1:0]         assembled;

  // newest dibit enters at the top: first received ends up in the low bits
  assign assembled = {dibit_i, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      idx_q       <= '0;
      first_q     <= 1'b0;
      byte_o      <= '0;
      valid_o     <= 1'b0;
      sof_o       <= 1'b0;
      eof_o       <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      sof_o       <= 1'b0;
      eof_o       <= end_i;
      align_err_o <= end_i && (idx_q != '0);
      if (start_i) begin
        idx_q   <= '0;
        first_q <= 1'b1;
      end else if (shift_i) begin
        sh_q <= assembled[BYTE_W-1:DIBIT_W];
        if (idx_q == IDX_LAST) begin
          idx_q   <= '0;
          byte_o  <= assembled;
          valid_o <= 1'b1;
          sof_o   <= first_q;
          first_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler #(
  parameter int DIBIT_W  = 2,
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rate_10m_i,
  input  logic               crs_dv_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               valid_o,
  output logic               sof_o,
  output logic               eof_o,
  output logic               align_err_o
);
  logic               crs_q, tick, restart, shift, start, fin;
  logic [DIBIT_W-1:0] rxd_q;

  rmii_rx_sampler #(.DIBIT_W(DIBIT_W), .SLOW_DIV(SLOW_DIV)) u_sampler (
    .clk_i, .rst_ni, .rate_10m_i, .crs_dv_i, .rxd_i,
    .restart_i(restart), .crs_o(crs_q), .rxd_o(rxd_q), .tick_o(tick)
  );

  rmii_rx_framer #(.DIBIT_W(DIBIT_W)) u_framer (
    .clk_i, .rst_ni, .crs_i(crs_q), .rxd_i(rxd_q), .tick_i(tick),
    .restart_o(restart), .shift_o(shift), .start_o(start), .end_o(fin)
  );

  rmii_rx_packer #(.DIBIT_W(DIBIT_W), .BYTE_W(BYTE_W)) u_packer (
    .clk_i, .rst_ni, .dibit_i(rxd_q), .shift_i(shift), .start_i(start),
    .end_i(fin), .byte_o, .valid_o, .sof_o, .eof_o, .align_err_o
  );
endmodule

// File: rtl/rmii_rx_assembler_chk.sv
module rmii_rx_assembler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic crs_dv_i,
  input logic valid_o,
  input logic sof_o,
  input logic eof_o,
  input logic align_err_o
);
  AST_SOF_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o);                                                      // R10
  AST_VALID_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);                                                   // R10
  AST_VALID_EOF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, eof_o}));                                             // R10
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!crs_dv_i, 2) |-> !valid_o);                                       // R4
  AST_EOF_AFTER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> $past(!crs_dv_i, 2));                                          // R6
  AST_EOF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);                                                       // R6
  AST_ERR_WITH_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> eof_o);                                                  // R7
endmodule

bind rmii_rx_assembler rmii_rx_assembler_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .crs_dv_i(crs_dv_i), .valid_o(valid_o),
  .sof_o(sof_o), .eof_o(eof_o), .align_err_o(align_err_o)
);

// File: tb/rmii_rx_assembler_test.sv
module rmii_rx_assembler_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rate_10m = 1'b0;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [7:0] byte_o;
  logic       valid_o, sof_o, eof_o, align_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unexp = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_eof;
    logic [7:0] data;
    logic       sof;
    logic       err;
    int         due;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  rmii_rx_assembler uut (
    .clk_i(clk), .rst_ni(rst_ni), .rate_10m_i(rate_10m), .crs_dv_i(crs_dv),
    .rxd_i(rxd), .byte_o(byte_o), .valid_o(valid_o), .sof_o(sof_o),
    .eof_o(eof_o), .align_err_o(align_err_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string act, input string expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard as results appear, checks value and cycle
  always @(negedge clk) begin
    if (rst_ni && (valid_o || eof_o)) begin
      if (exp_q.size() == 0) begin
        unexp++;
        check(1'b0, "R10 unexpected output",
              $sformatf("v=%0b e=%0b byte=%h", valid_o, eof_o, byte_o), "none");
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        if (!it.is_eof)
          check(valid_o && !eof_o && byte_o == it.data && sof_o == it.sof && cyc == it.due,
                {it.tag, "/R9 byte"},
                $sformatf("v=%0b byte=%h sof=%0b cyc=%0d", valid_o, byte_o, sof_o, cyc),
                $sformatf("v=1 byte=%h sof=%0b cyc=%0d", it.data, it.sof, it.due));
        else
          check(eof_o && !valid_o && align_err_o == it.err && cyc == it.due,
                {it.tag, "/R9 eof"},
                $sformatf("eof=%0b err=%0b cyc=%0d", eof_o, align_err_o, cyc),
                $sformatf("eof=1 err=%0b cyc=%0d", it.err, it.due));
      end
    end
  end

  task automatic drive(input logic crs, input logic [1:0] d, input int hold,
                       input bit push, input exp_t it);
    @(negedge clk);
    crs_dv = crs;
    rxd    = d;
    if (push) begin
      it.due = cyc + 2;
      exp_q.push_back(it);
    end
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic send_frame(input bit slow, input int nz, input int npre,
                            input logic [7:0] bytes[$], input int extra,
                            input string tag);
    exp_t it, none;
    int hold;
    hold = slow ? 10 : 1;
    @(negedge clk);
    rate_10m = slow;
    for (int i = 0; i < nz; i++)   drive(1'b1, 2'b00, hold, 1'b0, none);
    for (int i = 0; i < npre; i++) drive(1'b1, 2'b01, hold, 1'b0, none);
    drive(1'b1, 2'b11, hold, 1'b0, none);
    foreach (bytes[b]) begin
      for (int k = 0; k < 4; k++) begin
        it = '{1'b0, bytes[b], (b == 0), 1'b0, 0, tag};
        drive(1'b1, bytes[b][2*k +: 2], hold, (k == 3), it);
      end
    end
    for (int k = 0; k < extra; k++) drive(1'b1, 2'b10, hold, 1'b0, none);
    it = '{1'b1, 8'h00, 1'b0, (extra != 0), 0, (extra != 0) ? "R7" : "R6"};
    drive(1'b0, 2'b00, 1, 1'b1, it);
    for (int i = 0; i < 4; i++) drive(1'b0, 2'b00, 1, 1'b0, none);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    exp_t none;
    int u0;
    repeat (3) @(negedge clk);
    check(byte_o == 8'h00 && !valid_o && !sof_o && !eof_o && !align_err_o, "R1 reset",
          $sformatf("%h %0b%0b%0b%0b", byte_o, valid_o, sof_o, eof_o, align_err_o), "00 0000");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5: several bytes, long preamble, leading zeros
    send_frame(1'b0, 3, 7, '{8'hA5, 8'h3C, 8'hFF, 8'h00}, 0, "R2 R5");
    // R3: long run of forced zeros after strobe rise
    send_frame(1'b0, 12, 2, '{8'h81}, 0, "R3");

    // R4: out-of-band codes while strobe low
    u0 = unexp;
    drive(1'b0, 2'b11, 3, 1'b0, none);
    drive(1'b0, 2'b10, 2, 1'b0, none);
    drive(1'b0, 2'b01, 4, 1'b0, none);
    drive(1'b0, 2'b00, 3, 1'b0, none);
    check(unexp == u0, "R4 no output from out-of-band", $sformatf("%0d", unexp - u0), "0");
    send_frame(1'b0, 0, 3, '{8'h5A, 8'hC3}, 0, "R4");

    // R7: partial byte then strobe drop
    send_frame(1'b0, 2, 3, '{8'h12}, 2, "R7");
    send_frame(1'b0, 1, 3, '{}, 3, "R7");
    // R6: delimiter then immediate drop
    send_frame(1'b0, 1, 2, '{}, 0, "R6");

    // R11: abort before delimiter
    u0 = unexp;
    drive(1'b1, 2'b00, 2, 1'b0, none);
    for (int i = 0; i < 5; i++) drive(1'b1, 2'b01, 1, 1'b0, none);
    drive(1'b0, 2'b00, 8, 1'b0, none);
    check(unexp == u0 && exp_q.size() == 0, "R11 abort silent",
          $sformatf("%0d", unexp - u0), "0");

    // R8: 10 Mb/s frames
    send_frame(1'b1, 2, 4, '{8'h6E, 8'h01}, 0, "R8");
    send_frame(1'b1, 0, 3, '{8'hB7}, 3, "R8");
    send_frame(1'b0, 0, 1, '{8'h9C}, 0, "R8 back to 100M");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 all expected results seen",
          $sformatf("%0d", exp_q.size()), "0");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule